// File: doc/BRIEF.md
# Receive Link Health Monitor

This block sits on the recovered clock of a serial receive link, next to the transceiver. Each cycle it takes the transceiver's status flags and the ordered-set indications from the decoder: loss of synchronisation, invalid code group, disparity error, comma-bearing ordered set, initiate start-of-frame, normal end-of-frame and CRC failure. From these it decides whether the incoming signal can be trusted. It keeps the clock-recovery receiver held in reset until that point, so a dark or noisy input never starts clock recovery and leaves it stuck.

Six classes of condition each have a sticky flag and a saturating counter. A built-in-test or health-monitoring function reads the flags in parallel and reads the counters one at a time through a select input. A write-one-to-clear mask resets the flag and the counter of every class whose mask bit is set. The qualification threshold is an input, so the monitoring side can tune it.

Top module: `rx_link_health`

## Requirements
- R1: After reset `cdr_hold` is 1, every sticky flag is 0 and every counter reads 0.
- R2: A qualifying cycle has `comma_os`=1, `code_err`=0 and `sync_lost`=0. `cdr_hold` falls at the clock edge that samples the Nth qualifying cycle since the last restart, where N is `qual_target`, or 1 when `qual_target` is 0. A cycle with no comma and no error neither advances nor restarts the count.
- R3: While held, a cycle with `code_err`=1 or `sync_lost`=1 restarts the count from zero, and `cdr_hold` stays 1.
- R4: When `sync_lost` is sampled at 1 while released, `cdr_hold` returns to 1 at that edge and qualification starts again from zero. Code or disparity errors while released do not re-engage the hold.
- R5: Class 0 (loss of sync) records one event for each 0-to-1 transition of `sync_lost`. A level held for several cycles counts once.
- R6: Class 1 (code error) and class 2 (disparity error) each record one event for every cycle their input is 1, independently of each other.
- R7: Class 3 (initiate start-of-frame), class 4 (normal end-of-frame) and class 5 (CRC failure) each record one event for every cycle their input is 1.
- R8: `sticky[i]` goes to 1 at the edge that samples an event of class i. It stays 1 until a cycle with `clr_mask[i]`=1, which clears it. If an event and a clear of the same class arrive in the same cycle, the flag stays set.
- R9: `clr_mask[i]`=1 also zeroes counter i. If an event of class i arrives in the same cycle, the counter reads 1.
- R10: Each counter stops at 2^CNT_W-1 and holds that value while further events arrive.
- R11: `cnt_value` shows, without a clock, the counter of class `cnt_sel`. A select of 6 or above shows 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_lost | input | 1 | Transceiver reports loss of synchronisation |
| code_err | input | 1 | Invalid 8b/10b code group this cycle |
| disp_err | input | 1 | Running disparity error this cycle |
| comma_os | input | 1 | Comma-bearing ordered set received this cycle |
| sofi_det | input | 1 | Initiate-type start-of-frame detected |
| eofn_det | input | 1 | Normal-type end-of-frame detected |
| crc_err | input | 1 | CRC check of the finished frame failed |
| qual_target | input | QUAL_W | Number of qualifying ordered sets needed (0 means 1) |
| clr_mask | input | 6 | Write-one-to-clear strobe, one bit per class |
| cnt_sel | input | 3 | Class whose counter drives `cnt_value` |
| cdr_hold | output | 1 | Holds the clock-recovery receiver in reset while 1 |
| sticky | output | 6 | Sticky event flags, one per class |
| cnt_value | output | CNT_W | Counter of the selected class |

## Verification
The bench builds the block with CNT_W=6 and QUAL_W=4. The counters then saturate at 63, so a burst of 70 CRC failures shows the clamp of R10 within a short run, and the narrow target field lets the bench try a threshold of 3 and a threshold of 0. The qualification sequences mix idle cycles, code errors and loss-of-sync pulses around the threshold. A loss-of-sync level is held for several cycles, and clears arrive in the same cycle as events.

// File: rtl/lhm_pkg.sv
package lhm_pkg;

  localparam int NCLS = 6;

  typedef enum logic [2:0] {
    CLS_LOS  = 3'd0,
    CLS_CODE = 3'd1,
    CLS_DISP = 3'd2,
    CLS_SOFI = 3'd3,
    CLS_EOFN = 3'd4,
    CLS_CRC  = 3'd5
  } cls_e;

  // A programmed threshold of zero behaves as one ordered set.
  function automatic int unsigned effective_target(input int unsigned t);
    return (t == 0) ? 1 : t;
  endfunction

endpackage

// File: rtl/lhm_qualifier.sv
module lhm_qualifier #(
  parameter int QUAL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_lost,
  input  logic              code_err,
  input  logic              comma_os,
  input  logic [QUAL_W-1:0] qual_target,
  output logic              cdr_hold,
  output logic              link_drop,
  output logic              qual_step
);
  localparam int EW = QUAL_W + 1;

  logic [QUAL_W-1:0] run_q;
  logic              up_q;
  logic              restart;
  logic              qual_done;
  logic [EW-1:0]     run_inc;
  logic [EW-1:0]     goal;

  always_comb begin
    restart   = sync_lost | code_err;
    qual_step = ~up_q & comma_os & ~restart;
    run_inc   = {1'b0, run_q} + EW'(1);
    goal      = EW'(lhm_pkg::effective_target(32'(qual_target)));
    qual_done = qual_step & (run_inc >= goal);
    link_drop = up_q & sync_lost;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_q  <= 1'b0;
      run_q <= '0;
    end else if (sync_lost) begin
      up_q  <= 1'b0;
      run_q <= '0;
    end else if (qual_done) begin
      up_q  <= 1'b1;
      run_q <= '0;
    end else if (restart) begin
      run_q <= '0;
    end else if (qual_step) begin
      run_q <= run_inc[QUAL_W-1:0];
    end
  end

  assign cdr_hold = ~up_q;

endmodule

// File: rtl/lhm_event_detect.sv
module lhm_event_detect
  import lhm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_lost,
  input  logic            code_err,
  input  logic            disp_err,
  input  logic            sofi_det,
  input  logic            eofn_det,
  input  logic            crc_err,
  output logic [NCLS-1:0] evt
);
  logic sync_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_prev_q <= 1'b0;
    else        sync_prev_q <= sync_lost;
  end

  always_comb begin
    evt           = '0;
    evt[CLS_LOS]  = sync_lost & ~sync_prev_q;
    evt[CLS_CODE] = code_err;
    evt[CLS_DISP] = disp_err;
    evt[CLS_SOFI] = sofi_det;
    evt[CLS_EOFN] = eofn_det;
    evt[CLS_CRC]  = crc_err;
  end

endmodule

// File: rtl/lhm_class_stat.sv
module lhm_class_stat #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  output logic             sticky,
  output logic [CNT_W-1:0] count
);
  // Clear first, then one saturating increment.
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic             ev,
    input logic             wipe
  );
    logic [CNT_W-1:0] base;
    base = wipe ? '0 : cur;
    if (ev && (base != {CNT_W{1'b1}})) base = base + CNT_W'(1);
    return base;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky <= 1'b0;
      count  <= '0;
    end else begin
      sticky <= evt | (sticky & ~clr);
      count  <= next_count(count, evt, clr);
    end
  end

endmodule

// File: rtl/rx_link_health.sv
module rx_link_health #(
  parameter int QUAL_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_lost,
  input  logic                     code_err,
  input  logic                     disp_err,
  input  logic                     comma_os,
  input  logic                     sofi_det,
  input  logic                     eofn_det,
  input  logic                     crc_err,
  input  logic [QUAL_W-1:0]        qual_target,
  input  logic [lhm_pkg::NCLS-1:0] clr_mask,
  input  logic [2:0]               cnt_sel,
  output logic                     cdr_hold,
  output logic [lhm_pkg::NCLS-1:0] sticky,
  output logic [CNT_W-1:0]         cnt_value
);
  localparam int NCLS  = lhm_pkg::NCLS;
  localparam int SEL_W = 3;

  logic [NCLS-1:0]       evt;
  logic [NCLS*CNT_W-1:0] cnt_flat;
  logic                  link_drop;
  logic                  qual_step;

  lhm_qualifier #(.QUAL_W(QUAL_W)) i_qual (
    .clk(clk), .rst_n(rst_n), .sync_lost(sync_lost), .code_err(code_err),
    .comma_os(comma_os), .qual_target(qual_target), .cdr_hold(cdr_hold),
    .link_drop(link_drop), .qual_step(qual_step)
  );

  lhm_event_detect i_evt (
    .clk(clk), .rst_n(rst_n), .sync_lost(sync_lost), .code_err(code_err),
    .disp_err(disp_err), .sofi_det(sofi_det), .eofn_det(eofn_det),
    .crc_err(crc_err), .evt(evt)
  );

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    lhm_class_stat #(.CNT_W(CNT_W)) i_stat (
      .clk(clk), .rst_n(rst_n), .evt(evt[g]), .clr(clr_mask[g]),
      .sticky(sticky[g]), .count(cnt_flat[g*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    cnt_value = '0;
    for (int i = 0; i < NCLS; i++) begin
      if (cnt_sel == SEL_W'(i)) cnt_value = cnt_flat[i*CNT_W +: CNT_W];
    end
  end

endmodule

// File: rtl/lhm_checker.sv
module lhm_checker #(
  parameter int NCLS  = 6,
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sync_lost,
  input logic                  code_err,
  input logic                  comma_os,
  input logic                  cdr_hold,
  input logic                  link_drop,
  input logic                  qual_step,
  input logic [NCLS-1:0]       evt,
  input logic [NCLS-1:0]       clr_mask,
  input logic [NCLS-1:0]       sticky,
  input logic [NCLS*CNT_W-1:0] cnt_flat
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  p_release_needs_comma_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cdr_hold) |-> $past(comma_os && !code_err && !sync_lost));

  p_step_only_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    qual_step |-> cdr_hold);

  p_error_keeps_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cdr_hold && (code_err || sync_lost)) |=> cdr_hold);

  p_drop_rehold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    link_drop |=> cdr_hold);

  for (genvar g = 0; g < NCLS; g++) begin : g_chk
    p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt[g] |=> sticky[g]);

    p_count_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt[g] && !clr_mask[g]) |=> $stable(cnt_flat[g*CNT_W +: CNT_W]));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_flat[g*CNT_W +: CNT_W] == TOP && !clr_mask[g])
        |=> cnt_flat[g*CNT_W +: CNT_W] == TOP);
  end

endmodule

bind rx_link_health lhm_checker #(.NCLS(NCLS), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .sync_lost(sync_lost), .code_err(code_err),
  .comma_os(comma_os), .cdr_hold(cdr_hold), .link_drop(link_drop),
  .qual_step(qual_step), .evt(evt), .clr_mask(clr_mask), .sticky(sticky),
  .cnt_flat(cnt_flat)
);

// File: tb/test_rx_link_health.sv
module test_rx_link_health;
  localparam int PERIOD = 20;
  localparam int QW     = 4;
  localparam int CW     = 6;
  localparam int MAXC   = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_lost = 0, code_err = 0, disp_err = 0, comma_os = 0;
  logic sofi_det = 0, eofn_det = 0, crc_err = 0;
  logic [QW-1:0] qual_target = '0;
  logic [5:0] clr_mask = '0;
  logic [2:0] cnt_sel = '0;
  logic cdr_hold;
  logic [5:0] sticky;
  logic [CW-1:0] cnt_value;

  rx_link_health #(.QUAL_W(QW), .CNT_W(CW)) i_rx_link_health (
    .clk(clk), .rst_n(rst_n), .sync_lost(sync_lost), .code_err(code_err),
    .disp_err(disp_err), .comma_os(comma_os), .sofi_det(sofi_det),
    .eofn_det(eofn_det), .crc_err(crc_err), .qual_target(qual_target),
    .clr_mask(clr_mask), .cnt_sel(cnt_sel), .cdr_hold(cdr_hold),
    .sticky(sticky), .cnt_value(cnt_value)
  );

  always #(PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;

  // Reference model state
  bit m_hold = 1;
  int m_run  = 0;
  bit m_prev = 0;
  bit m_st[6];
  int m_cnt[6];

  typedef struct { bit hold; logic [5:0] st; string tag; } item_t;
  item_t sb[$];

  function automatic logic [5:0] pack_st();
    logic [5:0] v;
    for (int i = 0; i < 6; i++) v[i] = m_st[i];
    return v;
  endfunction

  // Driver: one clock cycle of stimulus and the expected result after its edge.
  task automatic step(input bit s, c, d, m, sf, ef, cr,
                      input logic [5:0] clr, input string tag);
    bit ev[6];
    int need;
    item_t it;
    @(negedge clk);
    sync_lost = s; code_err = c; disp_err = d; comma_os = m;
    sofi_det = sf; eofn_det = ef; crc_err = cr; clr_mask = clr;
    ev[0] = s && !m_prev; ev[1] = c; ev[2] = d;
    ev[3] = sf; ev[4] = ef; ev[5] = cr;
    m_prev = s;
    for (int i = 0; i < 6; i++) begin
      if (clr[i]) begin m_st[i] = 0; m_cnt[i] = 0; end
      if (ev[i]) begin
        m_st[i] = 1;
        if (m_cnt[i] < MAXC) m_cnt[i]++;
      end
    end
    need = (qual_target == 0) ? 1 : int'(qual_target);
    if (s) begin
      m_hold = 1; m_run = 0;
    end else if (m_hold) begin
      if (c) m_run = 0;
      else if (m) begin
        m_run++;
        if (m_run >= need) begin m_hold = 0; m_run = 0; end
      end
    end
    it.hold = m_hold; it.st = pack_st(); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 6'b0, tag);
  endtask

  // Monitor: pops one expected item per edge.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (cdr_hold !== it.hold) begin
        errors++;
        $display("FAIL %s: cdr_hold=%0b expected %0b", it.tag, cdr_hold, it.hold);
      end
      checks++;
      if (sticky !== it.st) begin
        errors++;
        $display("FAIL %s: sticky=%b expected %b", it.tag, sticky, it.st);
      end
    end
  end

  task automatic settle();
    @(posedge clk); #2;
  endtask

  task automatic check_cnt(input int sel, input int exp, input string tag);
    cnt_sel = sel[2:0];
    #1;
    checks++;
    if (cnt_value !== CW'(exp)) begin
      errors++;
      $display("FAIL %s: counter[%0d]=%0d expected %0d", tag, sel, cnt_value, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 6; i++) check_cnt(i, m_cnt[i], tag);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    checks++;
    if (cdr_hold !== 1'b1 || sticky !== 6'b0) begin
      errors++;
      $display("FAIL R1: hold=%0b sticky=%b expected 1 000000", cdr_hold, sticky);
    end
    check_all("R1 reset counters");

    // R2: threshold 3, idle cycle between commas neither advances nor restarts
    qual_target = 4'd3;
    step(0,0,0,1,0,0,0,6'b0,"R2 comma 1");
    step(0,0,0,1,0,0,0,6'b0,"R2 comma 2");
    idle("R2 idle gap");
    step(0,0,0,1,0,0,0,6'b0,"R2 comma 3 releases");
    idle("R2 released");
    // Errors while released do not re-engage (R4)
    step(0,1,1,1,0,0,0,6'b0,"R4 code error while up");
    // R4/R5: loss of sync pulse
    step(1,0,0,0,0,0,0,6'b0,"R4 drop");
    idle("R4 held again");
    settle();
    check_cnt(0, m_cnt[0], "R5 single pulse");
    // R3: code error during qualification restarts
    step(0,0,0,1,0,0,0,6'b0,"R3 comma a");
    step(0,0,0,1,0,0,0,6'b0,"R3 comma b");
    step(0,1,0,1,0,0,0,6'b0,"R3 error restart");
    step(0,0,0,1,0,0,0,6'b0,"R3 comma c");
    step(0,0,0,1,0,0,0,6'b0,"R3 comma d");
    step(1,0,0,1,0,0,0,6'b0,"R3 sync loss restart");
    step(0,0,0,1,0,0,0,6'b0,"R3 comma e");
    step(0,0,0,1,0,0,0,6'b0,"R3 comma f");
    step(0,0,0,1,0,0,0,6'b0,"R3 comma g releases");
    // R5: held level counts once
    step(1,0,0,0,0,0,0,6'b0,"R5 level 1");
    step(1,0,0,0,0,0,0,6'b0,"R5 level 2");
    step(1,0,0,0,0,0,0,6'b0,"R5 level 3");
    idle("R5 level end");
    settle();
    check_cnt(0, 3, "R5 level counted once");
    // R6/R7: separate classes
    step(0,1,0,0,0,0,0,6'b0,"R6 code only");
    step(0,0,1,0,0,0,0,6'b0,"R6 disp only");
    step(0,1,1,0,0,0,0,6'b0,"R6 both");
    step(0,0,0,0,1,0,0,6'b0,"R7 sofi");
    step(0,0,0,0,0,1,0,6'b0,"R7 eofn");
    step(0,0,0,0,1,1,1,6'b0,"R7 all frame");
    settle();
    check_all("R6 R7 class counts");
    // R8/R9: clear, and clear with coincident event
    step(0,0,0,0,0,0,0,6'b000110,"R8 clear code disp");
    step(0,0,0,0,1,0,0,6'b001000,"R9 clear with event");
    idle("R8 after clear");
    settle();
    check_cnt(1, 0, "R9 cleared code");
    check_cnt(3, 1, "R9 clear plus event");
    check_cnt(4, m_cnt[4], "R8 untouched class");
    // R10: saturation
    for (int k = 0; k < 70; k++) step(0,0,0,0,0,0,1,6'b0,"R10 crc burst");
    idle("R10 end");
    settle();
    check_cnt(5, MAXC, "R10 saturated");
    // R11: out-of-range select
    check_cnt(6, 0, "R11 select 6");
    check_cnt(7, 0, "R11 select 7");
    check_cnt(2, m_cnt[2], "R11 select 2");
    // R2: threshold 0 behaves as 1
    step(1,0,0,0,0,0,0,6'b0,"R2 drop before zero target");
    qual_target = 4'd0;
    idle("R2 idle held");
    step(0,0,0,1,0,0,0,6'b0,"R2 zero target releases");
    step(0,0,0,0,0,0,0,6'b111111,"R8 clear all");
    idle("R8 all clear");
    settle();
    check_all("R9 all counters cleared");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule